// File: doc/BRIEF.md
# Serial Management Slave with Strap-Loaded Address

This block is the management-side end of a two-wire serial management bus of the clause-22 kind. It runs on the management clock MDC and watches the serial data line for frames. A frame starts with a run of at least 32 ones and a 0-1 start pattern. It then carries an operation code, a target address, a register index, two turnaround bits and a 16-bit data word. When the target address matches its own, the block writes the word into a small register file, or it drives the addressed register back onto the line.

Two registers exist. The control register carries a self-clearing restart strobe and an interlocked power-down bit. The mode register holds the block's own bus address. That address is loaded from a single strap pin during reset, so only 0 or 1 can be selected there. Any higher address is set by writing the mode register once the bus has been reached at the strapped address. Both registers are driven out as ports to the surrounding logic.

Top module: `mgmt_slave_top`

## Requirements
- R1: While reset is low, the control register loads 0x1000, which has only the negotiation-enable bit 12 set, and the line driver is released (mdio_oe = 0).
- R2: A frame is recognised only after at least 32 consecutive ones followed by a 0 and then a 1. A shorter run of ones causes the frame to be ignored, with no drive and no register change.
- R3: A frame with opcode 01 (bits MSB first after the start pattern) and a matching address writes its 16 data bits, MSB first, into the addressed register. Control accepts bits 13, 12, 11, 10, 8 and the strobe bit 9. The mode register accepts bits 7:0. All other bits read as zero.
- R4: A frame with opcode 10 and a matching address is a read. The line stays released in the first turnaround bit period and is driven 0 in the second. The register's 16 bits then follow MSB first, one per MDC period, and the line is released after that.
- R5: Opcodes 00 and 11 are ignored, with no drive and no register change.
- R6: A frame whose 5-bit address (sent MSB first) differs from the current own address causes no drive and no register change.
- R7: The own address after reset equals the strap pin: 0 or 1, with the upper four bits zero.
- R8: The own address is mode register bits 4:0, which sits at register index 18. After that field is written, only frames at the new address get a response.
- R9: Writing 1 to control bit 9 makes it appear on ctrl_o for exactly one MDC cycle. It then returns to 0, and reads of the control register always return bit 9 as 0.
- R10: Control bit 11 (power-down) takes the written 1 only if the stored bit 12 is 0 at the time of the write. Otherwise bit 11 is written as 0.
- R11: A read of any register index other than 0 and 18 returns zero, and a write to such an index changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled and driven on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr_i | input | 1 | Strap value loaded as the own address during reset |
| mdio_i | input | 1 | Serial data line as seen by the block |
| mdio_o | output | 1 | Serial data value driven by the block |
| mdio_oe | output | 1 | High while the block drives the data line |
| ctrl_o | output | 16 | Current control register contents |
| modes_o | output | 16 | Current mode register contents |
| phy_addr_o | output | 5 | Current own bus address |

## Verification
The bench aims at the turnaround window of a read. A slave that starts driving one bit early would show up as an early enable in the first turnaround period, and one that shifts data wrongly would return the register rotated by one bit. It also sends a run of 31 preamble ones, which a counter with an off-by-one would wrongly accept. It exercises the power-down interlock in both orders of the enable bit, where a design that checked the new value rather than the stored one would accept a write it must refuse. Address migration is covered too: after the mode register is rewritten, the old address must go silent, and a design that kept matching the strap would still answer there.

// File: rtl/mgmt_pkg.sv
// Shared constants and types for the serial management slave.
// Assumes clause-22 style framing: 2-bit opcode, 5-bit addresses, 16-bit data.
package mgmt_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int OP_W    = 2;
    localparam int TA_W    = 2;
    localparam int PRE_LEN = 32;
    localparam int HDR_W   = OP_W + 2 * ADDR_W;
    localparam int CNT_W   = $clog2(PRE_LEN + 1);

    typedef enum logic [2:0] {
        FS_PRE,
        FS_START,
        FS_HDR,
        FS_TA,
        FS_DATA
    } frame_state_e;

    localparam logic [OP_W-1:0]   OP_WRITE  = 2'b01;
    localparam logic [OP_W-1:0]   OP_READ   = 2'b10;

    localparam logic [ADDR_W-1:0] IDX_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] IDX_MODES = 5'd18;

    localparam int BIT_RESTART = 9;
    localparam int BIT_PDOWN   = 11;
    localparam int BIT_ANEN    = 12;

    localparam logic [DATA_W-1:0] CTRL_RST     = 16'h1000;
    localparam logic [DATA_W-1:0] CTRL_KEEP    = 16'h3D00;
    localparam logic [DATA_W-1:0] MODES_KEEP   = 16'h00FF;
endpackage

// File: rtl/mdio_frame_rx.sv
// Frame engine: tracks preamble, start, header, turnaround and data phases.
// Assumes mdio_i is stable around the MDC rising edge; all state changes and
// line drive updates happen on that edge. Issues one registered write strobe
// at the end of an accepted write frame and serialises read data.
module mdio_frame_rx
    import mgmt_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    frame_state_e      state;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-2:0]  hdr_sh;
    logic [DATA_W-1:0] dat_sh;
    logic              do_rd;
    logic              do_wr;
    logic [ADDR_W-1:0] reg_q;

    logic [HDR_W-1:0]  full_hdr;
    logic [OP_W-1:0]   hdr_op;
    logic [ADDR_W-1:0] hdr_pa;
    logic              hdr_match;

    // Header as it stands including the bit on the line this cycle.
    always_comb begin
        full_hdr  = {hdr_sh, mdio_i};
        hdr_op    = full_hdr[HDR_W-1 -: OP_W];
        hdr_pa    = full_hdr[2*ADDR_W-1 -: ADDR_W];
        rd_addr   = full_hdr[ADDR_W-1:0];
        hdr_match = (hdr_pa == own_addr);
    end

    // Frame sequencing, data shifting and line drive.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            state   <= FS_PRE;
            cnt     <= '0;
            hdr_sh  <= '0;
            dat_sh  <= '0;
            do_rd   <= 1'b0;
            do_wr   <= 1'b0;
            reg_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            case (state)
                FS_PRE: begin
                    if (mdio_i) begin
                        if (cnt != CNT_W'(PRE_LEN)) cnt <= cnt + 1'b1;
                    end else begin
                        if (cnt == CNT_W'(PRE_LEN)) state <= FS_START;
                        cnt <= '0;
                    end
                end
                FS_START: begin
                    state <= mdio_i ? FS_HDR : FS_PRE;
                    cnt   <= '0;
                end
                FS_HDR: begin
                    hdr_sh <= full_hdr[HDR_W-2:0];
                    if (cnt == CNT_W'(HDR_W - 1)) begin
                        state  <= FS_TA;
                        cnt    <= '0;
                        do_rd  <= hdr_match && (hdr_op == OP_READ);
                        do_wr  <= hdr_match && (hdr_op == OP_WRITE);
                        reg_q  <= rd_addr;
                        dat_sh <= rd_data;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FS_TA: begin
                    if (cnt == '0) begin
                        cnt <= cnt + 1'b1;
                        if (do_rd) begin
                            mdio_oe <= 1'b1;
                            mdio_o  <= 1'b0;
                        end
                    end else begin
                        state <= FS_DATA;
                        cnt   <= '0;
                        if (do_rd) begin
                            mdio_o <= dat_sh[DATA_W-1];
                            dat_sh <= {dat_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                FS_DATA: begin
                    if (cnt == CNT_W'(DATA_W - 1)) begin
                        wr_en   <= do_wr;
                        wr_addr <= reg_q;
                        wr_data <= {dat_sh[DATA_W-2:0], mdio_i};
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                        do_rd   <= 1'b0;
                        do_wr   <= 1'b0;
                        state   <= FS_PRE;
                        cnt     <= '0;
                    end else begin
                        cnt    <= cnt + 1'b1;
                        if (do_rd) mdio_o <= dat_sh[DATA_W-1];
                        dat_sh <= {dat_sh[DATA_W-2:0], mdio_i};
                    end
                end
                default: begin
                    state <= FS_PRE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mgmt_regfile.sv
// Register file: control register with a one-cycle restart strobe and a
// power-down bit interlocked against negotiation enable, and a mode
// register whose low field is the own bus address, loaded from a strap
// pin during reset. Assumes at most one write strobe per cycle.
module mgmt_regfile
    import mgmt_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] modes_q
);
    logic [DATA_W-1:0] ctrl_wval;

    // Value a control write stores, with the power-down interlock applied.
    always_comb begin
        ctrl_wval = wr_data & (CTRL_KEEP | (DATA_W'(1) << BIT_RESTART));
        ctrl_wval[BIT_PDOWN] = wr_data[BIT_PDOWN] & ~ctrl_q[BIT_ANEN];
    end

    // Control register update; the restart strobe clears itself.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en && (wr_addr == IDX_CTRL)) begin
            ctrl_q <= ctrl_wval;
        end else begin
            ctrl_q[BIT_RESTART] <= 1'b0;
        end
    end

    // Mode register update; strap loads the address while reset is held.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            modes_q <= {{(DATA_W-1){1'b0}}, strap_i};
        end else if (wr_en && (wr_addr == IDX_MODES)) begin
            modes_q <= wr_data & MODES_KEEP;
        end
    end

    // Read mux; the strobe bit always reads back as zero.
    always_comb begin
        case (rd_addr)
            IDX_CTRL:  rd_data = ctrl_q & ~(DATA_W'(1) << BIT_RESTART);
            IDX_MODES: rd_data = modes_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mgmt_slave_top.sv
// Top of the serial management slave: frame engine plus register file.
// Assumes MDC is the only clock and reset is synchronous to it.
module mgmt_slave_top
    import mgmt_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              strap_addr_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] modes_o,
    output logic [ADDR_W-1:0] phy_addr_o
);
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    mdio_frame_rx u_rx (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_i   (mdio_i),
        .own_addr (phy_addr_o),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mgmt_regfile u_regs (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .strap_i (strap_addr_i),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_o),
        .modes_q (modes_o)
    );

    // Own address is the low field of the mode register.
    assign phy_addr_o = modes_o[ADDR_W-1:0];
endmodule

// File: rtl/mgmt_slave_chk.sv
// Checker for the serial management slave, bound to the top module.
// Assumes the synchronous active-low reset of the design.
module mgmt_slave_chk
    import mgmt_pkg::*;
(
    input logic              mdc,
    input logic              rst_n,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic [DATA_W-1:0] ctrl_o
);
    logic [4:0] oe_run;

    // Length of the current run of driven cycles.
    always_ff @(posedge mdc) begin
        if (!rst_n) oe_run <= '0;
        else if (mdio_oe) oe_run <= (oe_run == 5'd31) ? oe_run : oe_run + 1'b1;
        else oe_run <= '0;
    end

    a_r1_reset_state: assert property (@(posedge mdc)
        !rst_n |=> (ctrl_o == CTRL_RST && !mdio_oe));

    a_r9_restart_one_cycle: assert property (@(posedge mdc) disable iff (!rst_n)
        ctrl_o[BIT_RESTART] |=> !ctrl_o[BIT_RESTART]);

    a_r10_pdown_interlock: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(ctrl_o[BIT_PDOWN]) |-> !$past(ctrl_o[BIT_ANEN]));

    a_r4_turnaround_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    a_r4_drive_window: assert property (@(posedge mdc) disable iff (!rst_n)
        oe_run <= 5'd17);
endmodule

bind mgmt_slave_top mgmt_slave_chk u_chk (
    .mdc     (mdc),
    .rst_n   (rst_n),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .ctrl_o  (ctrl_o)
);

// File: tb/mgmt_slave_top_tb.sv
// Bench for the serial management slave: directed corners then seeded
// random frames, compared against a register model kept in the bench.
module mgmt_slave_top_tb;
    import mgmt_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b1;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic [15:0] ctrl_o;
    logic [15:0] modes_o;
    logic [4:0]  phy_addr_o;

    int          n_chk = 0;
    int          n_bad = 0;
    logic        done = 1'b0;
    logic        seen_oe;
    logic [15:0] m_ctrl;
    logic [15:0] m_modes;

    mgmt_slave_top u_dut (
        .mdc          (mdc),
        .rst_n        (rst_n),
        .strap_addr_i (strap),
        .mdio_i       (mdio_i),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .ctrl_o       (ctrl_o),
        .modes_o      (modes_o),
        .phy_addr_o   (phy_addr_o)
    );

    always #5 mdc = ~mdc;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Control value after a write per R3/R10 (strobe bit stored as 0).
    function automatic logic [15:0] ctrl_after(input logic [15:0] old, input logic [15:0] wd);
        logic [15:0] nv;
        nv = wd & 16'h3D00;
        nv[11] = wd[11] & ~old[12];
        return nv;
    endfunction

    task automatic drive_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge mdc);
            if (mdio_oe) seen_oe = 1'b1;
            mdio_i = v[i];
        end
    endtask

    task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                             input logic [4:0] ra, input logic [15:0] wd, input string req);
        logic        hit;
        logic        is_rd;
        logic        is_wr;
        logic [15:0] exp_rd;
        logic [15:0] got;
        int          oe_low;
        hit    = (pre >= 32) && (pa == m_modes[4:0]);
        is_rd  = hit && (op == 2'b10);
        is_wr  = hit && (op == 2'b01);
        exp_rd = (ra == 5'd0) ? m_ctrl : (ra == 5'd18) ? m_modes : 16'h0;
        seen_oe = 1'b0;
        drive_bits(32'h0, 1);
        drive_bits(32'hFFFF_FFFF, pre);
        drive_bits(32'h1, 2);
        drive_bits({30'h0, op}, 2);
        drive_bits({27'h0, pa}, 5);
        drive_bits({27'h0, ra}, 5);
        if (op == 2'b10) begin
            @(negedge mdc); mdio_i = 1'b1;
            chk({req, " first turnaround released"}, mdio_oe, 0);
            @(negedge mdc);
            if (is_rd) begin
                chk({req, " second turnaround driven"}, mdio_oe, 1);
                chk({req, " second turnaround zero"}, mdio_o, 0);
            end else if (mdio_oe) seen_oe = 1'b1;
            got = '0;
            oe_low = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge mdc);
                if (is_rd) begin
                    got[15-k] = mdio_o;
                    if (!mdio_oe) oe_low++;
                end else if (mdio_oe) seen_oe = 1'b1;
            end
            if (is_rd) begin
                chk({req, " read data"}, got, exp_rd);
                chk({req, " driven through data"}, oe_low, 0);
            end
            @(negedge mdc);
            chk({req, " released after data"}, mdio_oe, 0);
        end else begin
            drive_bits(32'h2, 2);
            drive_bits({16'h0, wd}, 16);
        end
        if (!is_rd) chk({req, " line never driven"}, seen_oe, 0);
        @(negedge mdc); mdio_i = 1'b1;
        @(negedge mdc);
        if (is_wr && ra == 5'd0) begin
            chk({req, " R9 strobe pulse"}, ctrl_o[9], wd[9]);
            m_ctrl = ctrl_after(m_ctrl, wd);
        end else if (is_wr && ra == 5'd18) begin
            m_modes = wd & 16'h00FF;
        end
        @(negedge mdc);
        chk({req, " control register"}, ctrl_o, m_ctrl);
        chk({req, " mode register"}, modes_o, m_modes);
        chk({req, " own address"}, phy_addr_o, m_modes[4:0]);
    endtask

    task automatic do_reset(input logic s);
        strap = s;
        @(negedge mdc); rst_n = 1'b0;
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        m_ctrl  = 16'h1000;
        m_modes = {15'h0, s};
        chk("R1 control reset value", ctrl_o, 16'h1000);
        chk("R1 line released in reset", mdio_oe, 0);
        chk("R7 strapped address", phy_addr_o, {4'h0, s});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b1);

        run_frame(32, 2'b10, 5'd1, 5'd0, 16'h0, "R4 read control");
        run_frame(32, 2'b10, 5'd0, 5'd0, 16'h0, "R6 read wrong address");
        run_frame(32, 2'b01, 5'd0, 5'd0, 16'h0000, "R6 write wrong address");
        run_frame(32, 2'b01, 5'd1, 5'd0, 16'h2100, "R3 write control");
        run_frame(32, 2'b10, 5'd1, 5'd0, 16'h0, "R3 read back control");
        run_frame(32, 2'b01, 5'd1, 5'd0, 16'h0800, "R10 power-down with enable clear");
        run_frame(32, 2'b01, 5'd1, 5'd0, 16'h1800, "R10 power-down kept as enable sets");
        run_frame(32, 2'b01, 5'd1, 5'd0, 16'h0800, "R10 power-down refused with enable set");
        run_frame(32, 2'b01, 5'd1, 5'd0, 16'h0200, "R9 restart strobe");
        run_frame(32, 2'b10, 5'd1, 5'd0, 16'h0, "R9 strobe reads zero");
        run_frame(32, 2'b00, 5'd1, 5'd0, 16'h3D00, "R5 opcode 00 ignored");
        run_frame(32, 2'b11, 5'd1, 5'd0, 16'h3D00, "R5 opcode 11 ignored");
        run_frame(31, 2'b01, 5'd1, 5'd0, 16'h2000, "R2 short preamble ignored");
        run_frame(32, 2'b01, 5'd1, 5'd0, 16'h2000, "R2 full preamble accepted");
        run_frame(32, 2'b10, 5'd1, 5'd7, 16'h0, "R11 unmapped read zero");
        run_frame(32, 2'b01, 5'd1, 5'd7, 16'hFFFF, "R11 unmapped write dropped");
        run_frame(32, 2'b01, 5'd1, 5'd18, 16'hFFA5, "R8 move own address");
        run_frame(32, 2'b10, 5'd1, 5'd18, 16'h0, "R8 old address silent");
        run_frame(32, 2'b10, 5'd5, 5'd18, 16'h0, "R8 new address answers");

        for (int n = 0; n < 60; n++) begin
            int          r;
            logic [1:0]  op;
            logic [4:0]  pa;
            logic [4:0]  ra;
            logic [15:0] wd;
            r  = $urandom % 8;
            op = (r < 3) ? 2'b01 : (r < 6) ? 2'b10 : (r == 6) ? 2'b00 : 2'b11;
            pa = ($urandom % 4 == 0) ? 5'($urandom) : m_modes[4:0];
            r  = $urandom % 3;
            ra = (r == 0) ? 5'd0 : (r == 1) ? 5'd18 : 5'($urandom);
            wd = 16'($urandom);
            if (pa != m_modes[4:0]) run_frame(32, op, pa, ra, wd, "R6 random");
            else if (op == 2'b01)   run_frame(32, op, pa, ra, wd, "R3 random");
            else if (op == 2'b10)   run_frame(32, op, pa, ra, wd, "R4 random");
            else                    run_frame(32, op, pa, ra, wd, "R5 random");
        end

        do_reset(1'b0);
        run_frame(32, 2'b10, 5'd0, 5'd0, 16'h0, "R7 read at strap zero");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge mdc);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule